// File: doc/BRIEF.md
# Configuration Address Translator

This block sits between a processor bus and a configuration target model. It turns processor accesses into type-0 configuration requests. It recognises two entry paths. The first is a 4 MB memory window based at 0x8080_0000. In that window the device is picked by a single select bit among the upper address bits, and the block encodes the position of that bit as a binary device number. The second path is a pair of I/O registers: an index register that holds the target location, and a data port that runs the cycle the index register points at.

Each processor access is a single-cycle `cpu_req` strobe. Any access that needs the target raises `cfg_req` and holds it until the target answers with `cfg_ack`. Every access, forwarded or not, ends with a one-cycle `cpu_done` pulse. On a read, `cpu_rdata` is valid during that pulse. Data is little-endian. Byte lanes come from the two low address bits and the size code.

Top module: `cfg_addr_xlat`

## Requirements
- R1: A memory access (`cpu_io`=0) starts a configuration request only when address bits 31:22 equal 0x202, which is the range 0x8080_0000 to 0x80BF_FFFF. Any other memory access raises no request, and a read of it returns all ones masked to the access size.
- R2: For a window access, `cfg_addr[15:11]` is the index k (0 to 10) of the lowest set bit among address bits 21:11 (bit 11+k). If none of those bits is set, the field is 11.
- R3: For a window access, `cfg_addr[10:0]` equals address bits 10:0: function in bits 10:8, register byte offset in bits 7:0.
- R4: Size code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. `cfg_be` is that many low ones shifted left by address bits 1:0, with lanes above bit 3 dropped. `cfg_wdata` is `cpu_wdata` shifted left by 8 times address bits 1:0. `cfg_wr` follows `cpu_wr`.
- R5: Read data is the target dword shifted right by 8 times address bits 1:0. Bytes at or above the access size are zero.
- R6: When `cfg_miss` is high alongside `cfg_ack`, a read returns all ones masked to the access size.
- R7: `cfg_req` and all request fields stay stable until a cycle in which `cfg_ack` is sampled high. In the next cycle `cfg_req` is low and `cpu_done` is high for exactly one cycle.
- R8: A `cpu_req` that arrives while a request is pending is ignored. The pending request's fields do not change, and no extra request or completion follows.
- R9: An I/O access (`cpu_io`=1) whose address bits 15:2 select 0xCF8 reaches a 32-bit index register. Writes update only the enabled byte lanes, and bits 1:0 always read as 0. No configuration request is raised.
- R10: An I/O access to 0xCFC to 0xCFF (address bits 15:2 = 0x33F) raises a request only when index bit 31 is 1 and index bits 23:16 are 0. The request has `cfg_addr` = {index[15:2], address[1:0]}. Otherwise the access raises no request, a read returns masked all ones, and a write is dropped.
- R11: Every access that raises no request, including I/O addresses other than the two ports, asserts `cpu_done` in the cycle after it is accepted.
- R12: After reset, `cfg_req` and `cpu_done` are low and the index register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access strobe, taken when no request is pending |
| cpu_io | input | 1 | 1 = I/O space access, 0 = memory space |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, right-aligned, valid with `cpu_done` |
| cfg_req | output | 1 | Configuration request pending |
| cfg_wr | output | 1 | Request is a write |
| cfg_addr | output | 16 | Device [15:11], function [10:8], register byte [7:0] |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Target response for the pending request |
| cfg_miss | input | 1 | With `cfg_ack`: no device answered |
| cfg_rdata | input | 32 | Target read dword, valid with `cfg_ack` |

## Verification
The bench drives window addresses with no select bit set, with a single select bit, and with several select bits set. A wrong encoder would report the highest set bit, or return 0 instead of 11 when no bit is set. It also hits both edges of the window, where a decoder one bit too wide or too narrow would forward accesses that belong elsewhere. It runs sub-dword accesses at every offset, including ones that run past the end of the dword; wrong lane logic shows up there as spilled byte enables or unmasked read bytes. The remaining cases are:
- the data port with its enable bit clear or a nonzero bus field;
- a strobe that arrives while a request is waiting;
- a target that answers with `cfg_miss`.

An error in any of these would show as a cycle that should not have been issued, a request whose fields change, or stale data returned in place of all ones.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   // Sequencer state of the translator
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } xlat_st_e;

   // Where an accepted access goes
   typedef enum logic [1:0] {
      K_LOCAL_ONES = 2'd0,
      K_INDEX      = 2'd1,
      K_TARGET     = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/cfgx_idsel_enc.sv
// Lowest-set-bit encoder; all-zero input yields N.
module cfgx_idsel_enc #(
   parameter int N = 11,
   parameter int W = 5
) (
   input  logic [N-1:0] sel,
   output logic [W-1:0] dev
);
   always_comb begin
      dev = W'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (sel[i]) dev = W'(i);
      end
   end
endmodule

// File: rtl/cfgx_lane_mask.sv
// Byte-enable generation from offset and size code.
module cfgx_lane_mask #(
   parameter int BYTES = 4,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] off,
   input  logic [1:0]       size,
   output logic [BYTES-1:0] be
);
   localparam int MW = 2 * BYTES;
   logic [MW-1:0] span;
   logic [MW-1:0] moved;

   for (genvar b = 0; b < MW; b++) begin : g_span
      if (b < BYTES) begin : g_low
         assign span[b] = (b < (1 << size));
      end else begin : g_high
         assign span[b] = 1'b0;
      end
   end

   assign moved = span << off;
   assign be    = moved[BYTES-1:0];
endmodule

// File: rtl/cfgx_wr_align.sv
// Moves right-aligned write data onto its byte lanes.
module cfgx_wr_align #(
   parameter int DW    = 32,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] off,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout
);
   assign dout = din << {off, 3'b000};
endmodule

// File: rtl/cfgx_rd_extract.sv
// Right-aligns a read dword and zeroes bytes beyond the access size.
module cfgx_rd_extract #(
   parameter int DW    = 32,
   parameter int BYTES = 4,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] off,
   input  logic [1:0]       size,
   input  logic [DW-1:0]    dword,
   output logic [DW-1:0]    dout
);
   logic [DW-1:0] shifted;
   assign shifted = dword >> {off, 3'b000};

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign dout[8*b +: 8] = (b < (1 << size)) ? shifted[8*b +: 8] : 8'h00;
   end
endmodule

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
   import cfgx_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            DW       = 32,
   parameter int            IO_W     = 16,
   parameter int            WIN_BITS = 22,
   parameter logic [AW-1:0] WIN_BASE = 32'h8080_0000,
   parameter int            IDSEL_LO = 11,
   parameter int            IDSEL_N  = 11,
   parameter logic [IO_W-1:0] IDX_OFS = 16'h0CF8,
   parameter logic [IO_W-1:0] DAT_OFS = 16'h0CFC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_req,
   input  logic                 cpu_io,
   input  logic                 cpu_wr,
   input  logic [1:0]           cpu_size,
   input  logic [AW-1:0]        cpu_addr,
   input  logic [DW-1:0]        cpu_wdata,
   output logic                 cpu_done,
   output logic [DW-1:0]        cpu_rdata,
   output logic                 cfg_req,
   output logic                 cfg_wr,
   output logic [IDSEL_LO+4:0]  cfg_addr,
   output logic [DW/8-1:0]      cfg_be,
   output logic [DW-1:0]        cfg_wdata,
   input  logic                 cfg_ack,
   input  logic                 cfg_miss,
   input  logic [DW-1:0]        cfg_rdata
);
   localparam int BYTES  = DW / 8;
   localparam int OFS_W  = $clog2(BYTES);
   localparam int DEV_W  = 5;
   localparam int CA_W   = DEV_W + IDSEL_LO;
   localparam int EN_BIT = DW - 1;
   localparam int BUS_LO = 16;
   localparam int BUS_HI = 23;

   // Elaboration-time parameter checks
   if (DW != 32) begin : g_chk_dw
      $error("cfg_addr_xlat: index register layout needs DW == 32");
   end
   if (IDSEL_LO + IDSEL_N > WIN_BITS) begin : g_chk_win
      $error("cfg_addr_xlat: select bits exceed the window");
   end
   if (IDSEL_N + 1 > (1 << DEV_W)) begin : g_chk_dev
      $error("cfg_addr_xlat: device field too narrow");
   end
   if (WIN_BITS >= AW || IO_W > AW) begin : g_chk_aw
      $error("cfg_addr_xlat: address width too small");
   end
   if (WIN_BASE[WIN_BITS-1:0] != '0) begin : g_chk_base
      $error("cfg_addr_xlat: window base not aligned to window size");
   end

   // Decode of the incoming access
   logic             win_hit, idx_hit, dat_hit, idx_en;
   logic [DEV_W-1:0] dev_num;
   logic [CA_W-1:0]  addr_mem, addr_io;
   acc_kind_e        kind;

   assign win_hit = !cpu_io && (cpu_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
   assign idx_hit = cpu_io && (cpu_addr[IO_W-1:OFS_W] == IDX_OFS[IO_W-1:OFS_W]);
   assign dat_hit = cpu_io && (cpu_addr[IO_W-1:OFS_W] == DAT_OFS[IO_W-1:OFS_W]);

   cfgx_idsel_enc #(.N(IDSEL_N), .W(DEV_W)) u_enc (
      .sel (cpu_addr[IDSEL_LO+IDSEL_N-1:IDSEL_LO]),
      .dev (dev_num)
   );

   logic [DW-1:0] idx_q, idx_nx;
   assign idx_en   = idx_q[EN_BIT] && (idx_q[BUS_HI:BUS_LO] == '0);
   assign addr_mem = {dev_num, cpu_addr[IDSEL_LO-1:0]};
   assign addr_io  = {idx_q[CA_W-1:OFS_W], cpu_addr[OFS_W-1:0]};

   always_comb begin
      if (win_hit || (dat_hit && idx_en)) kind = K_TARGET;
      else if (idx_hit)                   kind = K_INDEX;
      else                                kind = K_LOCAL_ONES;
   end

   // Lane steering for the incoming access
   logic [BYTES-1:0] be_now;
   logic [DW-1:0]    wlane_now;

   cfgx_lane_mask #(.BYTES(BYTES), .OFS_W(OFS_W)) u_mask (
      .off  (cpu_addr[OFS_W-1:0]),
      .size (cpu_size),
      .be   (be_now)
   );

   cfgx_wr_align #(.DW(DW), .OFS_W(OFS_W)) u_walign (
      .off  (cpu_addr[OFS_W-1:0]),
      .din  (cpu_wdata),
      .dout (wlane_now)
   );

   // Index register update with byte lanes; low bits stay clear
   always_comb begin
      idx_nx = idx_q;
      for (int b = 0; b < BYTES; b++) begin
         if (be_now[b]) idx_nx[8*b +: 8] = wlane_now[8*b +: 8];
      end
      idx_nx[OFS_W-1:0] = '0;
   end

   // Sequencer
   xlat_st_e         st_q;
   logic [OFS_W-1:0] off_q;
   logic [1:0]       size_q;
   logic [DW-1:0]    dword_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cfg_req   <= 1'b0;
         cfg_wr    <= 1'b0;
         cfg_addr  <= '0;
         cfg_be    <= '0;
         cfg_wdata <= '0;
         cpu_done  <= 1'b0;
         idx_q     <= '0;
         off_q     <= '0;
         size_q    <= '0;
         dword_q   <= '0;
      end else begin
         cpu_done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  off_q  <= cpu_addr[OFS_W-1:0];
                  size_q <= cpu_size;
                  unique case (kind)
                     K_TARGET: begin
                        cfg_req   <= 1'b1;
                        cfg_wr    <= cpu_wr;
                        cfg_addr  <= win_hit ? addr_mem : addr_io;
                        cfg_be    <= be_now;
                        cfg_wdata <= wlane_now;
                        st_q      <= ST_WAIT;
                     end
                     K_INDEX: begin
                        cpu_done <= 1'b1;
                        dword_q  <= idx_q;
                        if (cpu_wr) idx_q <= idx_nx;
                     end
                     default: begin
                        cpu_done <= 1'b1;
                        dword_q  <= '1;
                     end
                  endcase
               end
            end
            ST_WAIT: begin
               if (cfg_ack) begin
                  cfg_req  <= 1'b0;
                  cpu_done <= 1'b1;
                  dword_q  <= cfg_miss ? '1 : cfg_rdata;
                  st_q     <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   cfgx_rd_extract #(.DW(DW), .BYTES(BYTES), .OFS_W(OFS_W)) u_rext (
      .off   (off_q),
      .size  (size_q),
      .dword (dword_q),
      .dout  (cpu_rdata)
   );
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
   parameter int DW   = 32,
   parameter int CA_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_done,
   input logic            cfg_req,
   input logic            cfg_wr,
   input logic [CA_W-1:0] cfg_addr,
   input logic [DW/8-1:0] cfg_be,
   input logic [DW-1:0]   cfg_wdata,
   input logic            cfg_ack
);
   // R7: request and its fields held until acknowledged
   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_be)
                                 && $stable(cfg_wr) && $stable(cfg_wdata)));

   // R7: acknowledge ends the request and completes the access
   a_r7_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_ack) |=> (cpu_done && !cfg_req));

   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R8: no completion while a request is outstanding
   a_r8_no_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> !cpu_done);

   // R4: a forwarded request always enables at least one lane
   a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_be != '0));
endmodule

bind cfg_addr_xlat cfgx_chk #(.DW(DW), .CA_W(CA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_done  (cpu_done),
   .cfg_req   (cfg_req),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .cfg_ack   (cfg_ack)
);

// File: tb/cfg_addr_xlat_tb.sv
module cfg_addr_xlat_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_wr = 1'b0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        cfg_req, cfg_wr;
   logic [15:0] cfg_addr;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        cfg_ack = 1'b0, cfg_miss = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int total = 0;
   int bad   = 0;
   logic [31:0] idx_m = '0;

   always #4 clk = ~clk;

   cfg_addr_xlat u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_wr(cpu_wr),
      .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
      .cfg_miss(cfg_miss), .cfg_rdata(cfg_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] f_dev(input logic [31:0] a);
      for (int i = 0; i < 11; i++) if (a[11+i]) return 5'(i);
      return 5'd11;
   endfunction

   function automatic int f_nb(input logic [1:0] s);
      return (s >= 2) ? 4 : (1 << s);
   endfunction

   function automatic logic [3:0] f_be(input logic [1:0] off, input logic [1:0] s);
      logic [7:0] m;
      m = 8'((1 << f_nb(s)) - 1) << off;
      return m[3:0];
   endfunction

   function automatic logic [31:0] f_rd(input logic [1:0] off, input logic [1:0] s,
                                        input logic [31:0] dw);
      logic [31:0] sh, r;
      sh = dw >> (8 * off);
      r = '0;
      for (int b = 0; b < 4; b++) if (b < f_nb(s)) r[8*b +: 8] = sh[8*b +: 8];
      return r;
   endfunction

   task automatic run(input bit io, input logic [31:0] addr, input bit wr,
                      input logic [1:0] size, input logic [31:0] wd, input int delay,
                      input bit miss, input logic [31:0] td, input bit stray);
      bit win, ip, dp, ecfg, got;
      logic [15:0] eaddr, caddr;
      logic [31:0] erd, rd;
      string tg;
      win   = !io && (addr[31:22] == 10'h202);
      ip    = io && (addr[15:2] == 14'h33E);
      dp    = io && (addr[15:2] == 14'h33F);
      ecfg  = win || (dp && idx_m[31] && idx_m[23:16] == 8'h00);
      eaddr = win ? {f_dev(addr), addr[10:0]} : {idx_m[15:2], addr[1:0]};
      @(negedge clk);
      cpu_req = 1'b1; cpu_io = io; cpu_addr = addr; cpu_wr = wr;
      cpu_size = size; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      got = cfg_req;
      tg = io ? "R10" : "R1";
      chk(got == ecfg, tg, 32'(got), 32'(ecfg));
      if (got) begin
         caddr = cfg_addr;
         if (ecfg) begin
            if (win) begin
               chk(cfg_addr[15:11] == eaddr[15:11], "R2", 32'(cfg_addr[15:11]), 32'(eaddr[15:11]));
               chk(cfg_addr[10:0] == eaddr[10:0], "R3", 32'(cfg_addr[10:0]), 32'(eaddr[10:0]));
            end else begin
               chk(cfg_addr == eaddr, "R10", 32'(cfg_addr), 32'(eaddr));
            end
            chk(cfg_be == f_be(addr[1:0], size), "R4", 32'(cfg_be), 32'(f_be(addr[1:0], size)));
            chk(cfg_wr == wr, "R4", 32'(cfg_wr), 32'(wr));
            if (wr) chk(cfg_wdata == (wd << (8 * addr[1:0])), "R4", cfg_wdata,
                        wd << (8 * addr[1:0]));
         end
         if (stray) begin
            cpu_req = 1'b1; cpu_io = 1'b0; cpu_addr = 32'h8080_1234;
         end
         for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            cpu_req = 1'b0;
            chk(cfg_req && !cpu_done && cfg_addr == caddr, stray ? "R8" : "R7",
                32'(cfg_addr), 32'(caddr));
         end
         cfg_ack = 1'b1; cfg_miss = miss; cfg_rdata = td;
         @(negedge clk);
         cfg_ack = 1'b0; cfg_miss = 1'b0; cfg_rdata = '0;
         chk(cpu_done && !cfg_req, "R7", {cpu_done, cfg_req}, 32'h2);
         erd = f_rd(addr[1:0], size, miss ? 32'hFFFF_FFFF : td);
         tg = miss ? "R6" : "R5";
      end else begin
         chk(cpu_done, "R11", 32'(cpu_done), 32'h1);
         erd = f_rd(addr[1:0], size, ip ? idx_m : 32'hFFFF_FFFF);
         tg = ip ? "R9" : (io ? (dp ? "R10" : "R11") : "R1");
         if (ip && wr) begin
            for (int b = 0; b < 4; b++)
               if (f_be(addr[1:0], size)[b]) idx_m[8*b +: 8] = 8'((wd << (8 * addr[1:0])) >> (8 * b));
            idx_m[1:0] = 2'b00;
         end
      end
      rd = cpu_rdata;
      if (!wr) chk(rd == erd, tg, rd, erd);
      if (stray) begin
         repeat (2) @(negedge clk);
         chk(!cfg_req && !cpu_done, "R8", {cfg_req, cpu_done}, 32'h0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] a, w;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(!cfg_req && !cpu_done, "R12", {cfg_req, cpu_done}, 32'h0);
      rst_n = 1'b1;
      run(1, 32'h0000_0CF8, 0, 2'd2, 0, 0, 0, 0, 0);           // R12 index reads 0
      // R2 corners: no select bit, top select bit, all select bits
      run(0, 32'h8080_0000, 0, 2'd2, 0, 1, 0, 32'hA1B2C3D4, 0);
      run(0, 32'h80A0_0004, 0, 2'd2, 0, 0, 0, 32'h1122_3344, 0);
      run(0, 32'h80BF_FFFF, 0, 2'd0, 0, 2, 0, 32'h5566_7788, 0);
      // R1 window edges
      run(0, 32'h807F_FFFC, 0, 2'd2, 0, 0, 0, 0, 0);
      run(0, 32'h80C0_0000, 0, 2'd1, 0, 0, 0, 0, 0);
      // R4 lanes beyond the dword dropped
      run(0, 32'h8080_0803, 1, 2'd2, 32'hCAFE_BABE, 0, 0, 0, 0);
      run(0, 32'h8080_1002, 1, 2'd1, 32'h0000_BEEF, 1, 0, 0, 0);
      // R6 absent device
      run(0, 32'h8080_0800, 0, 2'd1, 0, 1, 1, 32'h1234_5678, 0);
      // R8 stray strobe during wait
      run(0, 32'h8081_0010, 0, 2'd2, 0, 3, 0, 32'hDEAD_0001, 1);
      // R10 data port disabled, bus nonzero, enabled
      run(1, 32'h0000_0CFC, 0, 2'd2, 0, 0, 0, 0, 0);
      run(1, 32'h0000_0CF8, 1, 2'd2, 32'h8005_1234, 0, 0, 0, 0);
      run(1, 32'h0000_0CFD, 0, 2'd0, 0, 1, 0, 32'h99AA_BBCC, 0);
      run(1, 32'h0000_0CFA, 1, 2'd0, 32'h0000_0000, 0, 0, 0, 0);
      run(1, 32'h0000_0CFE, 1, 2'd1, 32'h0000_4321, 2, 0, 0, 0);
      run(1, 32'h0000_0CF9, 1, 2'd0, 32'h0000_00FF, 0, 0, 0, 0); // R9 byte lane
      run(1, 32'h0000_0CF8, 0, 2'd2, 0, 0, 0, 0, 0);
      run(1, 32'h0000_0060, 0, 2'd2, 0, 0, 0, 0, 0);            // R11 other I/O
      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         int k;
         k = int'($urandom % 5);
         w = $urandom;
         case (k)
            0: begin
               int m;
               m = int'($urandom % 3);
               a = 32'h8080_0000 | ($urandom & 32'h7FF);
               if (m == 1) a |= 32'h800 << ($urandom % 11);
               else if (m == 2) a |= $urandom & 32'h003F_F800;
            end
            1: a = $urandom;
            2: begin
               a = 32'h0000_0CF8 | ($urandom & 3);
               if ($urandom % 2) w = {1'b1, w[30:24], 8'h00, w[15:0]};
            end
            3: a = 32'h0000_0CFC | ($urandom & 3);
            default: a = $urandom & 32'hFFFF;
         endcase
         run(k >= 2, a, 1'($urandom), 2'($urandom), w, int'($urandom % 4),
             1'($urandom), $urandom, 1'b0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule